// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses the address of the next instruction in a byte-addressed stream of fixed 32-bit instructions, which must sit on word boundaries. For each instruction it receives the current program counter, the primary opcode, the function code of register-format instructions, the 16-bit immediate, the 26-bit jump field, a register operand and a flag that says whether two register operands were equal. The register reads and the equality compare are done outside the block. From these inputs it decodes the control-flow kind and produces the next program counter. For calls it also produces a link value and a write enable aimed at the return-address register.

Requests enter and results leave through valid/ready handshakes, with one register stage between them. A request moves in when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high when the output slot is empty or is being drained in the same cycle. A result is offered on `out_valid` and stays unchanged until `out_ready` accepts it. A consumer that holds `out_ready` low stalls the producer after at most one accepted request.

Top module: `next_pc_unit`

## Requirements
- R1: An opcode outside {0, 2, 3, 4, 5} yields next PC = PC + 4, with link write and misalignment both low.
- R2: Opcode 4 (branch when equal) with the equality flag at 1 yields PC + 4 + (sign-extended immediate × 4). With the flag at 0 it yields PC + 4.
- R3: Opcode 5 (branch when unequal) takes the same target when the equality flag is 0, and yields PC + 4 when the flag is 1.
- R4: A branch immediate with bit 15 set is a negative word offset, so the target lies below PC + 4. The result wraps modulo 2^32.
- R5: Opcode 2 (jump) yields bits 31..28 of PC + 4, then the 26-bit field, then two zero bits. The link write stays low.
- R6: Opcode 3 (call) yields the same target as R5. It raises the link write, with link value PC + 4 and link register index 31.
- R7: Opcode 0 with function code 8 (register jump) and a register value whose bits 1..0 are 00 yields next PC = register value.
- R8: A register jump whose register value has nonzero bits 1..0 raises the misalignment flag and yields next PC = PC + 4.
- R9: Opcode 0 with any function code other than 8 is sequential, as in R1.
- R10: While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_ready` is low.
- R11: While reset is active and after it, before any request, `out_valid` is low and `in_ready` is high.
- R12: The link write is high only for a call result. It is never high together with the misalignment flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_pc | input | 32 | Current program counter |
| in_opcode | input | 6 | Primary opcode |
| in_funct | input | 6 | Function code for opcode 0 |
| in_imm | input | 16 | Branch word offset |
| in_jfield | input | 26 | Jump word address field |
| in_reg | input | 32 | Register operand for register jumps |
| in_eq | input | 1 | Register operands compared equal |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_next_pc | output | 32 | Next program counter |
| out_link_we | output | 1 | Write link value to return-address register |
| out_link_addr | output | 5 | Index of the return-address register (31) |
| out_link_value | output | 32 | Return address PC + 4 |
| out_misalign | output | 1 | Register jump target was not word aligned |

## Verification
A decode fault shows up as a wrong next PC or a wrong link write on the very next result that leaves the block. The one register stage means the error appears one cycle after the request is accepted. A wrong immediate extension or a wrong jump concatenation only shows for certain field values, which is why negative offsets, wrap-around and full-width jump fields are driven directly. A fault in the stage's hold logic shows up as a result that changes, or a result that is lost or duplicated, while the consumer stalls. This is visible as soon as `out_ready` is low for a cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [5:0] OPC_REGFMT = 6'd0;
  localparam logic [5:0] OPC_JUMP   = 6'd2;
  localparam logic [5:0] OPC_CALL   = 6'd3;
  localparam logic [5:0] OPC_BREQ   = 6'd4;
  localparam logic [5:0] OPC_BRNE   = 6'd5;
  localparam logic [5:0] FN_REGJMP  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BREQ = 3'd1,
    FLOW_BRNE = 3'd2,
    FLOW_JUMP = 3'd3,
    FLOW_CALL = 3'd4,
    FLOW_REGJ = 3'd5
  } flow_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output flow_kind_e  kind
);
  always_comb begin
    unique case (opcode)
      OPC_BREQ:   kind = FLOW_BREQ;
      OPC_BRNE:   kind = FLOW_BRNE;
      OPC_JUMP:   kind = FLOW_JUMP;
      OPC_CALL:   kind = FLOW_CALL;
      OPC_REGFMT: kind = (funct == FN_REGJMP) ? FLOW_REGJ : FLOW_SEQ;
      default:    kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int JUMP_W      = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JUMP_W-1:0] jfield,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] branch_pc,
  output logic [ADDR_W-1:0] jump_pc
);
  localparam int SHIFT    = $clog2(INSTR_BYTES);
  localparam int EXT_W    = ADDR_W - IMM_W - SHIFT;
  localparam int REGION_W = ADDR_W - JUMP_W - SHIFT;

  logic [ADDR_W-1:0] byte_offset;

  assign seq_pc      = pc + ADDR_W'(INSTR_BYTES);
  assign byte_offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
  assign branch_pc   = seq_pc + byte_offset;

  generate
    if (REGION_W > 0) begin : g_region
      assign jump_pc = {seq_pc[ADDR_W-1 -: REGION_W], jfield, {SHIFT{1'b0}}};
    end else begin : g_flat
      assign jump_pc = {jfield[ADDR_W-SHIFT-1:0], {SHIFT{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  flow_kind_e        kind,
  input  logic              regs_equal,
  input  logic [ADDR_W-1:0] reg_value,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] branch_pc,
  input  logic [ADDR_W-1:0] jump_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              link_we,
  output logic              misalign
);
  localparam int SHIFT = $clog2(INSTR_BYTES);

  logic reg_unaligned;
  assign reg_unaligned = |reg_value[SHIFT-1:0];

  always_comb begin
    next_pc  = seq_pc;
    link_we  = 1'b0;
    misalign = 1'b0;
    unique case (kind)
      FLOW_BREQ: if (regs_equal)  next_pc = branch_pc;
      FLOW_BRNE: if (!regs_equal) next_pc = branch_pc;
      FLOW_JUMP: next_pc = jump_pc;
      FLOW_CALL: begin
        next_pc = jump_pc;
        link_we = 1'b1;
      end
      FLOW_REGJ: begin
        if (reg_unaligned) misalign = 1'b1;
        else               next_pc  = reg_value;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_stage.sv
module npc_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  logic             full_q;
  logic [WIDTH-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int JUMP_W      = 26,
  parameter int INSTR_BYTES = 4,
  parameter int REGIDX_W    = 5,
  parameter int LINK_REG    = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_pc,
  input  logic [5:0]          in_opcode,
  input  logic [5:0]          in_funct,
  input  logic [IMM_W-1:0]    in_imm,
  input  logic [JUMP_W-1:0]   in_jfield,
  input  logic [ADDR_W-1:0]   in_reg,
  input  logic                in_eq,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   out_next_pc,
  output logic                out_link_we,
  output logic [REGIDX_W-1:0] out_link_addr,
  output logic [ADDR_W-1:0]   out_link_value,
  output logic                out_misalign
);
  localparam int PAY_W = 2 * ADDR_W + 2;

  flow_kind_e        kind;
  logic [ADDR_W-1:0] seq_pc, branch_pc, jump_pc, next_pc;
  logic              link_we, misalign;
  logic [PAY_W-1:0]  pay_in, pay_out;

  npc_decode u_decode (
    .opcode (in_opcode),
    .funct  (in_funct),
    .kind   (kind)
  );

  npc_targets #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JUMP_W(JUMP_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_targets (
    .pc        (in_pc),
    .imm       (in_imm),
    .jfield    (in_jfield),
    .seq_pc    (seq_pc),
    .branch_pc (branch_pc),
    .jump_pc   (jump_pc)
  );

  npc_select #(
    .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_select (
    .kind       (kind),
    .regs_equal (in_eq),
    .reg_value  (in_reg),
    .seq_pc     (seq_pc),
    .branch_pc  (branch_pc),
    .jump_pc    (jump_pc),
    .next_pc    (next_pc),
    .link_we    (link_we),
    .misalign   (misalign)
  );

  assign pay_in = {next_pc, link_we, misalign, seq_pc};

  npc_stage #(.WIDTH(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_next_pc    = pay_out[PAY_W-1 -: ADDR_W];
  assign out_link_we    = pay_out[ADDR_W+1];
  assign out_misalign   = pay_out[ADDR_W];
  assign out_link_value = pay_out[ADDR_W-1:0];
  assign out_link_addr  = REGIDX_W'(LINK_REG);
endmodule

// File: rtl/npc_checker.sv
module npc_checker
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 16,
  parameter int JUMP_W   = 26,
  parameter int REGIDX_W = 5,
  parameter int LINK_REG = 31
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [ADDR_W-1:0]   in_pc,
  input logic [5:0]          in_opcode,
  input logic [5:0]          in_funct,
  input logic [ADDR_W-1:0]   in_reg,
  input logic                out_valid,
  input logic                out_ready,
  input logic [ADDR_W-1:0]   out_next_pc,
  input logic                out_link_we,
  input logic [REGIDX_W-1:0] out_link_addr,
  input logic [ADDR_W-1:0]   out_link_value,
  input logic                out_misalign
);
  logic fire, plain_op;
  assign fire     = in_valid && in_ready;
  assign plain_op = !(in_opcode inside {OPC_REGFMT, OPC_JUMP, OPC_CALL, OPC_BREQ, OPC_BRNE});

  a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    fire && plain_op |=> out_valid && out_next_pc == $past(in_pc) + 32'd4 && !out_link_we && !out_misalign);

  a_r6_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_opcode == OPC_CALL |=> out_link_we && out_link_value == $past(in_pc) + 32'd4
      && out_link_addr == REGIDX_W'(LINK_REG));

  a_r8_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_opcode == OPC_REGFMT && in_funct == FN_REGJMP && in_reg[1:0] != 2'b00
      |=> out_misalign && out_next_pc == $past(in_pc) + 32'd4);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_link_we)
      && $stable(out_misalign) && $stable(out_link_value));

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r11_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_link_we && out_misalign));
endmodule

bind next_pc_unit npc_checker #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JUMP_W(JUMP_W), .REGIDX_W(REGIDX_W), .LINK_REG(LINK_REG)
) u_npc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
  .in_opcode(in_opcode), .in_funct(in_funct), .in_reg(in_reg), .out_valid(out_valid),
  .out_ready(out_ready), .out_next_pc(out_next_pc), .out_link_we(out_link_we),
  .out_link_addr(out_link_addr), .out_link_value(out_link_value), .out_misalign(out_misalign)
);

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [5:0]  in_opcode = '0;
  logic [5:0]  in_funct = '0;
  logic [15:0] in_imm = '0;
  logic [25:0] in_jfield = '0;
  logic [31:0] in_reg = '0;
  logic        in_eq = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_next_pc;
  logic        out_link_we;
  logic [4:0]  out_link_addr;
  logic [31:0] out_link_value;
  logic        out_misalign;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] npc;
    logic        lwe;
    logic        mis;
    logic [31:0] lval;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [31:0] held_npc;
  logic        held_valid = 1'b0;

  always #2.5 clk = ~clk;

  next_pc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_opcode(in_opcode), .in_funct(in_funct), .in_imm(in_imm), .in_jfield(in_jfield),
    .in_reg(in_reg), .in_eq(in_eq), .out_valid(out_valid), .out_ready(out_ready),
    .out_next_pc(out_next_pc), .out_link_we(out_link_we), .out_link_addr(out_link_addr),
    .out_link_value(out_link_value), .out_misalign(out_misalign)
  );

  function automatic exp_t model(logic [31:0] pc, logic [5:0] op, logic [5:0] fn,
                                 logic [15:0] imm, logic [25:0] jf, logic [31:0] rv, logic eq);
    exp_t e;
    logic [31:0] p4, br, jt;
    p4 = pc + 32'd4;
    br = p4 + {{14{imm[15]}}, imm, 2'b00};
    jt = {p4[31:28], jf, 2'b00};
    e.npc = p4; e.lwe = 1'b0; e.mis = 1'b0; e.lval = p4; e.tag = "R1";
    case (op)
      6'd4: begin e.tag = imm[15] ? "R4" : "R2"; if (eq)  e.npc = br; end
      6'd5: begin e.tag = imm[15] ? "R4" : "R3"; if (!eq) e.npc = br; end
      6'd2: begin e.tag = "R5"; e.npc = jt; end
      6'd3: begin e.tag = "R6"; e.npc = jt; e.lwe = 1'b1; end
      6'd0: begin
        if (fn == 6'd8) begin
          if (rv[1:0] != 2'b00) begin e.tag = "R8"; e.mis = 1'b1; end
          else begin e.tag = "R7"; e.npc = rv; end
        end else e.tag = "R9";
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One cycle: set inputs at negedge, settle, score, then let the edge happen.
  task automatic step(bit v, logic [31:0] pc, logic [5:0] op, logic [5:0] fn, logic [15:0] imm,
                      logic [25:0] jf, logic [31:0] rv, logic eq, bit rdy);
    @(negedge clk);
    if (held_valid) begin
      check(out_valid == 1'b1, "R10", "valid dropped while stalled", 32'(out_valid), 32'd1);
      check(out_next_pc == held_npc, "R10", "next pc changed while stalled", out_next_pc, held_npc);
    end
    in_valid = v; in_pc = pc; in_opcode = op; in_funct = fn; in_imm = imm;
    in_jfield = jf; in_reg = rv; in_eq = eq; out_ready = rdy;
    #1;
    if (out_valid && !out_ready)
      check(in_ready == 1'b0, "R10", "in_ready high while stalled", 32'(in_ready), 32'd0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result", out_next_pc, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_next_pc == e.npc, e.tag, "next pc", out_next_pc, e.npc);
        check(out_link_we == e.lwe, (e.lwe ? "R6" : "R12"), "link write", 32'(out_link_we), 32'(e.lwe));
        check(out_misalign == e.mis, (e.mis ? "R8" : e.tag), "misalign", 32'(out_misalign), 32'(e.mis));
        if (e.lwe) begin
          check(out_link_value == e.lval, "R6", "link value", out_link_value, e.lval);
          check(out_link_addr == 5'd31, "R6", "link index", 32'(out_link_addr), 32'd31);
        end
      end
    end
    held_valid = out_valid && !out_ready;
    held_npc   = out_next_pc;
    if (in_valid && in_ready) exp_q.push_back(model(pc, op, fn, imm, jf, rv, eq));
  endtask

  task automatic go(logic [31:0] pc, logic [5:0] op, logic [5:0] fn, logic [15:0] imm,
                    logic [25:0] jf, logic [31:0] rv, logic eq);
    step(1'b1, pc, op, fn, imm, jf, rv, eq, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    check(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11", "in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 32'd1);

    // Directed corner cases
    go(32'h0000_1000, 6'd8,  6'd0, 16'h0003, '0, '0, 1'b0);             // R1
    go(32'h0000_1000, 6'd4,  6'd0, 16'h0010, '0, '0, 1'b1);             // R2 taken
    go(32'h0000_1000, 6'd4,  6'd0, 16'h0010, '0, '0, 1'b0);             // R2 not taken
    go(32'h0000_1000, 6'd5,  6'd0, 16'h0010, '0, '0, 1'b0);             // R3 taken
    go(32'h0000_1000, 6'd5,  6'd0, 16'h0010, '0, '0, 1'b1);             // R3 not taken
    go(32'h0000_1000, 6'd4,  6'd0, 16'hFFFF, '0, '0, 1'b1);             // R4 back one word
    go(32'h0000_0000, 6'd4,  6'd0, 16'h8000, '0, '0, 1'b1);             // R4 wrap
    go(32'hFFFF_FFFC, 6'd8,  6'd0, 16'h0000, '0, '0, 1'b0);             // R1 wrap
    go(32'h7FFF_FFFC, 6'd2,  6'd0, 16'h0000, 26'h3FF_FFFF, '0, 1'b0);   // R5 region from PC+4
    go(32'hA000_0040, 6'd3,  6'd0, 16'h0000, 26'h000_1234, '0, 1'b0);   // R6
    go(32'h0000_2000, 6'd0,  6'd8, 16'h0000, '0, 32'hDEAD_BEE0, 1'b0);  // R7
    go(32'h0000_2000, 6'd0,  6'd8, 16'h0000, '0, 32'hDEAD_BEE2, 1'b0);  // R8
    go(32'h0000_2000, 6'd0,  6'd8, 16'h0000, '0, 32'h0000_0001, 1'b0);  // R8
    go(32'h0000_2000, 6'd0,  6'd9, 16'h0000, '0, 32'h0000_1000, 1'b0);  // R9
    // R10: stall with a call result held
    step(1'b1, 32'h0000_3000, 6'd3, 6'd0, 16'h0, 26'h0ABCDE, '0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++)
      step(1'b1, 32'h0000_4000, 6'd2, 6'd0, 16'h0, 26'h000111, '0, 1'b0, 1'b0);
    step(1'b0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1);
    step(1'b0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] op, fn;
      logic [31:0] rv;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: op = 6'd4;
        2, 3: op = 6'd5;
        4:    op = 6'd2;
        5:    op = 6'd3;
        6, 7: op = 6'd0;
        default: op = 6'($urandom);
      endcase
      fn = ($urandom_range(0, 2) != 0) ? 6'd8 : 6'($urandom);
      rv = $urandom;
      if ($urandom_range(0, 1) == 0) rv[1:0] = 2'b00;
      step($urandom_range(0, 3) != 0, {$urandom} & 32'hFFFF_FFFC, op, fn, 16'($urandom),
           26'($urandom), rv, 1'($urandom), $urandom_range(0, 3) != 0);
    end
    for (int k = 0; k < 4; k++) step(1'b0, '0, '0, '0, '0, '0, '0, 1'b0, 1'b1);
    check(exp_q.size() == 0, "R10", "results lost", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule